// File: doc/BRIEF.md
# Overflow Event Timer with Autoreload

This block is a general-purpose up-counter that signals an event when it wraps past its all-ones value. Software picks an event N counts ahead by loading the all-ones value minus N and starting the counter. The overflow then comes on the (N+1)-th increment. With autoreload off, the timer fires once and stops. With autoreload on, the stored load value is copied back into the counter on every wrap. The period is then 2^WIDTH minus the load value, which gives a steady tick. For a tick rate derived from an input rate, load all-ones minus (input rate / tick rate − 1).

A small register port controls the timer. It has a control word (run and autoreload bits), the load value, the live counter, a pending-overflow status bit that is cleared by writing a one, and an interrupt enable. A start does not take effect at once. The counter holds the new value for a fixed resynchronisation latency before it begins to count. A direct write to the counter while running applies the same latency.

Top module: `ovf_timer`

## Requirements
- R1: After synchronous reset, every readable register is zero and `irq` is low.
- R2: A write to CTRL (address 0) with bit 0 (run) set while stopped copies LOAD into the counter and sets run. The counter holds that value and first increments on the START_LAT-th rising edge after the write edge (the third, by default).
- R3: While running with no latency pending and no write to CTRL or COUNT, the counter increases by one on each clock.
- R4: With CTRL bit 1 (autoreload) clear, an increment from all-ones sets the counter to zero, clears run and sets the pending bit. The counter then stays at zero.
- R5: With autoreload set, an increment from all-ones copies LOAD into the counter, keeps run, sets pending and continues counting with no extra latency. The period is 2^WIDTH − LOAD cycles.
- R6: A write to CTRL with bit 0 clear stops the counter in the same edge and leaves its value unchanged.
- R7: A write to COUNT (address 2) replaces the counter value. If the timer is running, counting resumes after the same latency as a start.
- R8: A write to STATUS (address 3) with bit 0 set clears the pending bit. A write with bit 0 clear has no effect.
- R9: If an overflow and a pending-clear write fall on the same edge, the bit stays pending.
- R10: `irq` is high exactly when the pending bit is set and IEN (address 4) bit 0 is set.
- R11: Reads return CTRL as {autoreload, run} in bits 1:0, LOAD, the live counter, the pending bit in STATUS bit 0 and IEN bit 0. Other addresses read zero.
- R12: A LOAD write while running does not change the counter. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 CTRL, 1 LOAD, 2 COUNT, 3 STATUS, 4 IEN) |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Combinational read data for `addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
A register write is captured on the edge where `wr_en` is sampled high, and its register reads back before the next edge. A start or a running counter write holds the counter through two more edges, and it moves on the third edge after the write. An overflow updates the counter, run and pending on the same edge, and `irq` follows within that cycle. The bench drives inputs one nanosecond after a rising edge and samples at the falling edge. It steps its reference model on each rising edge, so every comparison counts these exact edge offsets.

// File: rtl/otm_pkg.sv
package otm_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_LOAD  = 3'd1,
        A_COUNT = 3'd2,
        A_STAT  = 3'd3,
        A_IEN   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic autoreload;
        logic run;
    } ctrl_t;

    function automatic logic hit(input logic we, input logic [ADDR_W-1:0] a,
                                 input reg_addr_e target);
        return we && (a == target);
    endfunction

endpackage

// File: rtl/otm_regs.sv
module otm_regs
    import otm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              run_i,
    output logic              start_o,
    output logic              stop_o,
    output logic              cnt_wr_o,
    output logic              st_clr_o,
    output logic              autoreload_o,
    output logic [WIDTH-1:0]  load_o,
    output logic              ien_o
);
    logic ctrl_hit;
    assign ctrl_hit = hit(wr_en, addr, A_CTRL);

    assign start_o  = ctrl_hit && wdata[0] && !run_i;
    assign stop_o   = ctrl_hit && !wdata[0];
    assign cnt_wr_o = hit(wr_en, addr, A_COUNT);
    assign st_clr_o = hit(wr_en, addr, A_STAT) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            autoreload_o <= 1'b0;
            load_o       <= '0;
            ien_o        <= 1'b0;
        end else begin
            if (ctrl_hit)                   autoreload_o <= wdata[1];
            if (hit(wr_en, addr, A_LOAD))   load_o       <= wdata;
            if (hit(wr_en, addr, A_IEN))    ien_o        <= wdata[0];
        end
    end
endmodule

// File: rtl/otm_core.sv
module otm_core #(
    parameter int WIDTH     = 32,
    parameter int START_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cnt_wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] load_i,
    input  logic             autoreload_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             run_o,
    output logic             cnt_en_o,
    output logic             ovf_o
);
    localparam int DLY_W = (START_LAT > 2) ? $clog2(START_LAT) : 1;
    localparam logic [DLY_W-1:0] LAT_M1 = DLY_W'(START_LAT - 1);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [DLY_W-1:0] dly_q;
    logic             sw_touch;

    assign sw_touch = start_i || stop_i || cnt_wr_i;
    assign cnt_en_o = run_o && (dly_q == '0);
    assign ovf_o    = cnt_en_o && (cnt_o == ALL_ONES) && !sw_touch;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            run_o <= 1'b0;
            dly_q <= '0;
        end else if (start_i) begin
            cnt_o <= load_i;
            run_o <= 1'b1;
            dly_q <= LAT_M1;
        end else if (stop_i) begin
            run_o <= 1'b0;
            dly_q <= '0;
        end else if (cnt_wr_i) begin
            cnt_o <= wdata_i;
            dly_q <= run_o ? LAT_M1 : '0;
        end else if (run_o) begin
            if (dly_q != '0) begin
                dly_q <= dly_q - 1'b1;
            end else if (cnt_o == ALL_ONES) begin
                if (autoreload_i) begin
                    cnt_o <= load_i;
                end else begin
                    cnt_o <= '0;
                    run_o <= 1'b0;
                end
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/otm_irq.sv
module otm_irq (
    input  logic clk,
    input  logic rst,
    input  logic ovf_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic pend_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst)        pend_o <= 1'b0;
        else if (ovf_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end

    assign irq_o = pend_o && ien_i;
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
    import otm_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int START_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    output logic              irq
);
    logic             start_p, stop_p, cnt_wr_p, st_clr_p;
    logic             ar_q, ien_q, run_q, cnt_en, ovf, pend_q;
    logic [WIDTH-1:0] load_q, cnt_q;
    ctrl_t            ctrl_rd;

    otm_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .run_i(run_q), .start_o(start_p), .stop_o(stop_p), .cnt_wr_o(cnt_wr_p),
        .st_clr_o(st_clr_p), .autoreload_o(ar_q), .load_o(load_q), .ien_o(ien_q)
    );

    otm_core #(.WIDTH(WIDTH), .START_LAT(START_LAT)) u_core (
        .clk(clk), .rst(rst), .start_i(start_p), .stop_i(stop_p),
        .cnt_wr_i(cnt_wr_p), .wdata_i(wdata), .load_i(load_q),
        .autoreload_i(ar_q), .cnt_o(cnt_q), .run_o(run_q),
        .cnt_en_o(cnt_en), .ovf_o(ovf)
    );

    otm_irq u_irq (
        .clk(clk), .rst(rst), .ovf_i(ovf), .clr_i(st_clr_p), .ien_i(ien_q),
        .pend_o(pend_q), .irq_o(irq)
    );

    assign ctrl_rd = '{autoreload: ar_q, run: run_q};

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {{(WIDTH-2){1'b0}}, ctrl_rd};
            A_LOAD:  rdata = load_q;
            A_COUNT: rdata = cnt_q;
            A_STAT:  rdata = {{(WIDTH-1){1'b0}}, pend_q};
            A_IEN:   rdata = {{(WIDTH-1){1'b0}}, ien_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk
    import otm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wd0,
    input logic              irq,
    input logic              run,
    input logic              cnt_en,
    input logic [WIDTH-1:0]  cnt,
    input logic [WIDTH-1:0]  load,
    input logic              ar,
    input logic              pend,
    input logic              ien,
    input logic              ovf
);
    localparam logic [WIDTH-1:0] TOP = '1;

    p_start_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && wd0 && !run) |=> (run && !cnt_en && cnt == $past(load)));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt != TOP && !wr_en) |=> (cnt == $past(cnt) + 1'b1));

    p_oneshot_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt == TOP && !ar && !wr_en) |=> (!run && cnt == '0 && pend));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt == TOP && ar && !wr_en) |=> (run && cnt_en && cnt == $past(load) && pend));

    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && !wd0) |=> (!run && $stable(cnt)));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STAT && wd0 && !ovf) |=> !pend);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |=> pend);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend && ien));
endmodule

bind ovf_timer ovf_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wd0(wdata[0]),
    .irq(irq), .run(run_q), .cnt_en(cnt_en), .cnt(cnt_q), .load(load_q),
    .ar(ar_q), .pend(pend_q), .ien(ien_q), .ovf(ovf)
);

// File: tb/ovf_timer_tb.sv
`timescale 1ns/1ps
module ovf_timer_tb;
    localparam int W = 32;
    localparam int LAT = 3;
    localparam logic [W-1:0] MAX = '1;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [2:0]   addr;
    logic [W-1:0] wdata;
    logic [W-1:0] rdata;
    logic         irq;

    int    n_tot = 0;
    int    n_bad = 0;
    string tag = "R11";
    bit    done = 0;

    always #2.5 clk = ~clk;

    ovf_timer #(.WIDTH(W), .START_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    logic [W-1:0] m_cnt, m_load;
    logic         m_run, m_ar, m_pend, m_ien;
    int           m_dly;

    always @(posedge clk) begin
        logic [W-1:0] o_cnt, o_load;
        logic         o_run, ovf;
        if (rst) begin
            m_cnt = 0; m_load = 0; m_run = 0; m_ar = 0;
            m_pend = 0; m_ien = 0; m_dly = 0;
        end else begin
            o_cnt = m_cnt; o_load = m_load; o_run = m_run; ovf = 0;
            if (m_run) begin
                if (m_dly > 0) m_dly = m_dly - 1;
                else if (m_cnt == MAX) begin
                    ovf = 1;
                    if (m_ar) m_cnt = o_load;
                    else begin m_cnt = 0; m_run = 0; end
                end else m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                case (addr)
                    3'd0: begin
                        if (wdata[0] && !o_run) begin
                            m_cnt = o_load; m_run = 1; m_dly = LAT - 1; ovf = 0;
                        end else if (!wdata[0]) begin
                            m_cnt = o_cnt; m_run = 0; m_dly = 0; ovf = 0;
                        end
                        m_ar = wdata[1];
                    end
                    3'd1: m_load = wdata;
                    3'd2: begin
                        m_cnt = wdata; m_run = o_run; ovf = 0;
                        m_dly = o_run ? LAT - 1 : 0;
                    end
                    3'd3: if (wdata[0]) m_pend = 0;
                    3'd4: m_ien = wdata[0];
                    default: ;
                endcase
            end
            if (ovf) m_pend = 1;
        end
    end

    function automatic logic [W-1:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_ar, m_run};
            3'd1: return m_load;
            3'd2: return m_cnt;
            3'd3: return {31'd0, m_pend};
            3'd4: return {31'd0, m_ien};
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({tag, " model rdata"}, rdata, model_rd(addr));
            chk({tag, " model irq"}, {31'd0, irq}, {31'd0, m_pend && m_ien});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic summary();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_tot++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [W-1:0] prev, v;
        int reloads;
        rst = 1; wr_en = 0; addr = 0; wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset values
        tag = "R1";
        for (int a = 0; a < 5; a++) begin
            addr = 3'(a);
            @(negedge clk);
            chk("R1 reset register", rdata, 0);
            chk("R1 reset irq", {31'd0, irq}, 0);
        end

        // R2, R3, R4: one-shot run from MAX-5
        tag = "R2";
        wr(3'd4, 1);
        wr(3'd1, MAX - 5);
        wr(3'd0, 32'd1);
        addr = 3'd2;
        @(negedge clk); chk("R2 start copies load", rdata, MAX - 5);
        repeat (2) begin @(negedge clk); chk("R2 held during latency", rdata, MAX - 5); end
        tag = "R3";
        @(negedge clk); chk("R3 first increment", rdata, MAX - 4);
        tag = "R4";
        repeat (5) @(negedge clk);
        chk("R4 wrap to zero", rdata, 0);
        chk("R10 irq raised", {31'd0, irq}, 1);
        addr = 3'd0;
        @(negedge clk); chk("R4 run cleared", rdata, 0);
        addr = 3'd2;
        repeat (3) @(negedge clk);
        chk("R4 counter holds", rdata, 0);

        // R8: write-one-to-clear
        tag = "R8";
        wr(3'd3, 0);
        addr = 3'd3;
        @(negedge clk); chk("R8 zero write ignored", rdata, 1);
        wr(3'd3, 1);
        @(negedge clk); chk("R8 one clears", rdata, 0);
        chk("R8 irq dropped", {31'd0, irq}, 0);

        // R10: enable gating
        tag = "R10";
        wr(3'd4, 0);
        wr(3'd1, MAX);
        wr(3'd0, 32'd1);
        addr = 3'd3;
        repeat (4) @(negedge clk);
        chk("R10 pending set", rdata, 1);
        chk("R10 irq masked", {31'd0, irq}, 0);
        wr(3'd4, 1);
        @(negedge clk); chk("R10 irq unmasked", {31'd0, irq}, 1);
        wr(3'd3, 1);

        // R5: autoreload, period 4
        tag = "R5";
        wr(3'd1, MAX - 3);
        wr(3'd0, 32'd3);
        addr = 3'd2;
        prev = 0; reloads = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rdata == MAX - 3 && prev == MAX) reloads++;
            prev = rdata;
        end
        chk("R5 reload count in 40 cycles", 32'(reloads), 9);
        addr = 3'd0;
        @(negedge clk); chk("R5 still running", rdata, 3);

        // R12: load change while running
        tag = "R12";
        wr(3'd1, MAX - 1);
        addr = 3'd2;
        repeat (10) @(negedge clk);
        chk("R12 new period used", {31'd0, rdata >= MAX - 1}, 1);

        // R7: counter write while running
        tag = "R7";
        wr(3'd2, 32'd5);
        @(negedge clk); chk("R7 written value", rdata, 5);
        repeat (2) begin @(negedge clk); chk("R7 held during latency", rdata, 5); end
        @(negedge clk); chk("R7 resumes", rdata, 6);

        // R9: clear and overflow on the same edge
        tag = "R9";
        wr(3'd2, MAX - 1);
        repeat (3) @(posedge clk);
        #1 wr_en = 1; addr = 3'd3; wdata = 1;
        @(posedge clk); #1 wr_en = 0;
        @(negedge clk); chk("R9 overflow beats clear", rdata, 1);

        // R6: stop holds value
        tag = "R6";
        wr(3'd0, 32'd2);
        addr = 3'd2;
        @(negedge clk); v = rdata;
        repeat (3) @(negedge clk);
        chk("R6 value frozen", rdata, v);
        addr = 3'd0;
        @(negedge clk); chk("R6 run clear, autoreload kept", rdata, 2);

        // R11: readback and unmapped address
        tag = "R11";
        wr(3'd1, 32'h1234_5678);
        addr = 3'd1;
        @(negedge clk); chk("R11 load readback", rdata, 32'h1234_5678);
        addr = 3'd6;
        @(negedge clk); chk("R11 unmapped reads zero", rdata, 0);

        summary();
    end
endmodule